// File: doc/BRIEF.md
# Linked-Frame Context Save Engine

This block moves a processor's register context between the register file and memory when a call, a trap or an interrupt is taken, and moves it back on return. Contexts live in fixed 16-word frames, each 64-byte aligned. Unused frames form a free list in memory. Frames in use form a chain of earlier contexts. Word 0 of every frame is a link word that threads the frame onto one list or the other. The engine holds two pointers: the head of the free list and the most recent saved context.

A save takes the frame at the head of the free list. It first reads that frame's link word to find the next free frame. It then writes 15 context words, and finally writes the old previous-context pointer into the link word. A restore does the inverse: it reads the link of the newest frame and reloads the 15 words into the registers. It then puts the frame back on the free list by writing the old free pointer into its link. Each context is either the lower half or the upper half of the register set. Four address registers are global and never travel in a frame.

Requests arrive as single-cycle pulses. The memory port moves one word per beat under a valid/ready handshake. Saves read registers through a combinational read port. Restores write registers, the program counter and the status word through write strobes.

Top module: `ctx_save_engine`

## Requirements
- R1: A save with a non-zero free pointer F reads the link at F. It then writes frame words 1 to 15 at F+4·w in ascending order. Last, it writes the old previous pointer to F. After that, free becomes the fetched link and previous becomes F.
- R2: Register index encoding is 0–15 for data registers D0–D15 and 16–31 for address registers A0–A15. Lower frames hold word 1 = program counter, words 2–9 = D0–D7 and words 10–15 = A2–A7. Upper frames hold word 1 = status word, words 2–9 = D8–D15 and words 10–15 = A10–A15.
- R3: A restore with a non-zero previous pointer P reads the link at P. It then reads words 1 to 15 and writes each to its register (or to the program counter or status word), in ascending order. Last, it writes the old free pointer to P. After that, previous becomes the fetched link and free becomes P.
- R4: Register indices 16, 17, 24 and 25 (A0, A1, A8, A9) are never written by a restore.
- R5: A save requested while the free pointer is zero pulses error for one cycle. It makes no memory beat, raises neither busy nor done, and leaves both pointers unchanged.
- R6: A restore requested while the previous pointer is zero behaves as in R5.
- R7: busy is high from the cycle after an accepted request through the final beat. done pulses for exactly one cycle after the final beat, with busy low.
- R8: A beat completes only when valid and ready are both high. While valid is high and ready is low, the address and direction stay unchanged.
- R9: Requests seen while busy are ignored. When several arrive together, one is served in priority order: save upper, save lower, restore upper, restore lower. The rest are dropped.
- R10: The low 6 bits of every fetched link are cleared before use, so both pointers stay 64-byte aligned.
- R11: After reset the free pointer equals the RESET_FREE parameter, the previous pointer is zero, and busy, done, error and valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_upper | input | 1 | Request: save upper context |
| save_lower | input | 1 | Request: save lower context |
| restore_upper | input | 1 | Request: restore upper context |
| restore_lower | input | 1 | Request: restore lower context |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle pulse on a refused request |
| free_ptr | output | XLEN | Head of the free frame list |
| prev_ptr | output | XLEN | Most recently saved frame |
| rf_rd_idx | output | 5 | Register read index |
| rf_rd_data | input | XLEN | Register read data (combinational) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 5 | Register write index |
| rf_wr_data | output | XLEN | Write data for register, PC and status writes |
| pc_i | input | XLEN | Current program counter |
| psw_i | input | XLEN | Current status word |
| pc_we | output | 1 | Load program counter from rf_wr_data |
| psw_we | output | 1 | Load status word from rf_wr_data |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat direction, 1 = write |
| mem_addr | output | XLEN | Byte address of the beat |
| mem_wdata | output | XLEN | Write data |
| mem_ready | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | XLEN | Read data |

## Verification
Two things can land in the same clock edge: a save request and a restore request, or a new request and an operation already in flight. The bench raises save upper and restore lower in one cycle. The save must win, shown by an upper frame written at the expected address and the pointers moving as for a save. During that same save it pulses save lower. After done, nothing may happen: the expected-beat queue must drain exactly and busy and valid must stay low. Memory ready is toggled by a pseudo-random pattern, so stalled beats are exercised throughout.

// File: rtl/csx_pkg.sv
package csx_pkg;
    localparam int FRAME_WORDS     = 16;
    localparam int WORD_W          = $clog2(FRAME_WORDS);
    localparam int RIDX_W          = WORD_W + 1;
    localparam int SYS_WORD        = 1;
    localparam int DREG_FIRST_WORD = 2;
    localparam int DREGS_PER_CTX   = 8;
    localparam int AREG_FIRST_WORD = DREG_FIRST_WORD + DREGS_PER_CTX;
    localparam int LOWER_AREG_BASE = 2;
    localparam int UPPER_AREG_BASE = 10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LINK_RD = 2'd1,
        ST_BODY    = 2'd2,
        ST_LINK_WR = 2'd3
    } csx_state_e;

    typedef enum logic [1:0] {
        SLOT_LINK = 2'd0,
        SLOT_SYS  = 2'd1,
        SLOT_REG  = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/csx_req_arb.sv
module csx_req_arb #(
    parameter int N_REQ = 4
) (
    input  logic [N_REQ-1:0]         req,
    input  logic                     enable,
    output logic                     grant,
    output logic [$clog2(N_REQ)-1:0] grant_idx
);
    localparam int GI_W = $clog2(N_REQ);

    // Lowest index wins: the loop walks downwards so the last hit is kept.
    always_comb begin
        grant     = 1'b0;
        grant_idx = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (enable && req[i]) begin
                grant     = 1'b1;
                grant_idx = GI_W'(i);
            end
        end
    end
endmodule

// File: rtl/csx_slot_map.sv
module csx_slot_map
    import csx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              upper,
    output slot_kind_e        kind,
    output logic [RIDX_W-1:0] idx
);
    logic [WORD_W-1:0] num;
    logic              bank;

    always_comb begin
        kind = SLOT_REG;
        num  = '0;
        bank = 1'b0;
        if (word == '0) begin
            kind = SLOT_LINK;
        end else if (word == WORD_W'(SYS_WORD)) begin
            kind = SLOT_SYS;
        end else if (word < WORD_W'(AREG_FIRST_WORD)) begin
            bank = 1'b0;
            num  = word - WORD_W'(DREG_FIRST_WORD)
                 + (upper ? WORD_W'(DREGS_PER_CTX) : '0);
        end else begin
            bank = 1'b1;
            num  = word - WORD_W'(AREG_FIRST_WORD)
                 + (upper ? WORD_W'(UPPER_AREG_BASE) : WORD_W'(LOWER_AREG_BASE));
        end
        idx = {bank, num};
    end
endmodule

// File: rtl/csx_seq.sv
module csx_seq
    import csx_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter logic [XLEN-1:0]  RESET_FREE = 32'h0000_0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_save,
    input  logic              start_upper,
    input  logic              mem_ready,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic [XLEN-1:0]   body_wdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              body_rd_beat,
    output logic [WORD_W-1:0] word,
    output logic              upper,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [XLEN-1:0]   free_ptr,
    output logic [XLEN-1:0]   prev_ptr
);
    localparam int                OFS_W      = WORD_W + 2;
    localparam logic [XLEN-1:0]   ALIGN_MASK = {{(XLEN-OFS_W){1'b1}}, {OFS_W{1'b0}}};
    localparam logic [WORD_W-1:0] LAST_WORD  = WORD_W'(FRAME_WORDS - 1);

    typedef struct packed {
        csx_state_e        st;
        logic              save;
        logic              upper;
        logic [WORD_W-1:0] word;
        logic [XLEN-1:0]   frame;
        logic [XLEN-1:0]   link;
        logic [XLEN-1:0]   free;
        logic [XLEN-1:0]   prev;
        logic              done;
        logic              err;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d            = q;
        d.done       = 1'b0;
        d.err        = 1'b0;
        mem_valid    = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = q.frame;
        mem_wdata    = '0;
        body_rd_beat = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (start_save ? (q.free == '0) : (q.prev == '0)) begin
                        d.err = 1'b1;
                    end else begin
                        d.st    = ST_LINK_RD;
                        d.save  = start_save;
                        d.upper = start_upper;
                        d.frame = start_save ? q.free : q.prev;
                    end
                end
            end
            ST_LINK_RD: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    d.link = mem_rdata & ALIGN_MASK;
                    d.word = WORD_W'(SYS_WORD);
                    d.st   = ST_BODY;
                end
            end
            ST_BODY: begin
                mem_valid = 1'b1;
                mem_we    = q.save;
                mem_addr  = q.frame + {{(XLEN-OFS_W){1'b0}}, q.word, 2'b00};
                mem_wdata = q.save ? body_wdata : '0;
                if (mem_ready) begin
                    body_rd_beat = !q.save;
                    if (q.word == LAST_WORD) begin
                        d.st = ST_LINK_WR;
                    end else begin
                        d.word = q.word + 1'b1;
                    end
                end
            end
            ST_LINK_WR: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = q.save ? q.prev : q.free;
                if (mem_ready) begin
                    if (q.save) begin
                        d.free = q.link;
                        d.prev = q.frame;
                    end else begin
                        d.prev = q.link;
                        d.free = q.frame;
                    end
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.free  <= RESET_FREE;
        end else begin
            q <= d;
        end
    end

    assign word     = q.word;
    assign upper    = q.upper;
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign free_ptr = q.free;
    assign prev_ptr = q.prev;

    // R8: a stalled beat keeps its address and direction
    p_beat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R10: both pointers stay frame aligned
    p_ptr_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((free_ptr & ~ALIGN_MASK) == '0) && ((prev_ptr & ~ALIGN_MASK) == '0));

    // R7: completion is a single-cycle pulse seen while idle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5 / R6: a refused request leaves the pointers alone
    p_err_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(free_ptr) && $stable(prev_ptr) && !busy));

    // R9: busy only ever starts from an accepted request
    p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/ctx_save_engine.sv
module ctx_save_engine
    import csx_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_FREE = 32'h0000_0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_upper,
    input  logic              save_lower,
    input  logic              restore_upper,
    input  logic              restore_lower,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [XLEN-1:0]   free_ptr,
    output logic [XLEN-1:0]   prev_ptr,
    output logic [RIDX_W-1:0] rf_rd_idx,
    input  logic [XLEN-1:0]   rf_rd_data,
    output logic              rf_wr_en,
    output logic [RIDX_W-1:0] rf_wr_idx,
    output logic [XLEN-1:0]   rf_wr_data,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   psw_i,
    output logic              pc_we,
    output logic              psw_we,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_ready,
    input  logic [XLEN-1:0]   mem_rdata
);
    localparam int N_REQ = 4;
    localparam int GI_W  = $clog2(N_REQ);

    logic [N_REQ-1:0]  req_vec;
    logic              grant;
    logic [GI_W-1:0]   grant_idx;
    logic              g_save, g_upper;
    logic              body_rd_beat;
    logic [WORD_W-1:0] cur_word;
    logic              cur_upper;
    slot_kind_e        slot_kind;
    logic [RIDX_W-1:0] slot_idx;
    logic [XLEN-1:0]   body_wdata;

    // Index order is the service priority: lowest index first.
    assign req_vec = {restore_lower, restore_upper, save_lower, save_upper};

    csx_req_arb #(.N_REQ(N_REQ)) u_arb (
        .req       (req_vec),
        .enable    (!busy),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    assign g_save  = (grant_idx < GI_W'(2));
    assign g_upper = !grant_idx[0];

    csx_seq #(.XLEN(XLEN), .RESET_FREE(RESET_FREE)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (grant),
        .start_save   (g_save),
        .start_upper  (g_upper),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .body_wdata   (body_wdata),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .body_rd_beat (body_rd_beat),
        .word         (cur_word),
        .upper        (cur_upper),
        .busy         (busy),
        .done         (done),
        .err          (error),
        .free_ptr     (free_ptr),
        .prev_ptr     (prev_ptr)
    );

    csx_slot_map u_map (
        .word  (cur_word),
        .upper (cur_upper),
        .kind  (slot_kind),
        .idx   (slot_idx)
    );

    assign rf_rd_idx  = slot_idx;
    assign body_wdata = (slot_kind == SLOT_SYS) ? (cur_upper ? psw_i : pc_i) : rf_rd_data;

    assign rf_wr_idx  = slot_idx;
    assign rf_wr_data = mem_rdata;
    assign rf_wr_en   = body_rd_beat && (slot_kind == SLOT_REG);
    assign pc_we      = body_rd_beat && (slot_kind == SLOT_SYS) && !cur_upper;
    assign psw_we     = body_rd_beat && (slot_kind == SLOT_SYS) &&  cur_upper;

    // R4: global address registers are never targets of a restore
    p_no_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> !(rf_wr_idx == RIDX_W'(16) || rf_wr_idx == RIDX_W'(17) ||
                       rf_wr_idx == RIDX_W'(24) || rf_wr_idx == RIDX_W'(25)));

    // R3: register, PC and status strokes are mutually exclusive
    p_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_wr_en, pc_we, psw_we}));
endmodule

// File: tb/ctx_save_engine_tb_top.sv
`timescale 1ns/1ps
module ctx_save_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        su = 0, sl = 0, ru = 0, rl = 0;
    logic        busy, done, err;
    logic [31:0] free_ptr, prev_ptr;
    logic [4:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata;
    logic        rf_wr_en, pc_we, psw_we, mem_valid, mem_we, mem_ready;
    logic [31:0] mem [256];
    logic [31:0] rf [32];
    logic [31:0] orig_rf [32];
    logic [31:0] pc_r, psw_r, orig_pc, orig_psw;
    logic [7:0]  lf = 8'hA5;

    always #2 clk = ~clk;

    assign rf_rd_data = rf[rf_rd_idx];
    assign mem_rdata  = mem[mem_addr[9:2]];
    assign mem_ready  = lf[0] | lf[2];

    always @(posedge clk) begin
        #1 lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end

    ctx_save_engine #(.XLEN(32), .RESET_FREE(32'h40)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .save_upper(su), .save_lower(sl), .restore_upper(ru), .restore_lower(rl),
        .busy(busy), .done(done), .error(err),
        .free_ptr(free_ptr), .prev_ptr(prev_ptr),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .pc_i(pc_r), .psw_i(psw_r), .pc_we(pc_we), .psw_we(psw_we),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [31:0] d;
    } ev_t;
    ev_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_free, m_prev;
    logic        hold_pend = 0, hold_we;
    logic [31:0] hold_a;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] d);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R1 R3 unexpected beat", a, 32'hFFFF_FFFF);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind && e.a == a, "R2 beat slot", a, e.a);
            check(e.d == d, "R1 R3 beat data", d, e.d);
        end
    endtask

    // Monitor: compares every write the design issues against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                check(mem_valid && mem_addr == hold_a && mem_we == hold_we, "R8 stalled beat held", mem_addr, hold_a);
            hold_pend = mem_valid && !mem_ready;
            hold_a    = mem_addr;
            hold_we   = mem_we;
            if (mem_valid && mem_ready && mem_we) begin
                observe(0, mem_addr, mem_wdata);
                mem[mem_addr[9:2]] = mem_wdata;
            end
            if (rf_wr_en) begin
                observe(1, {27'd0, rf_wr_idx}, rf_wr_data);
                rf[rf_wr_idx] = rf_wr_data;
            end
            if (pc_we) begin
                observe(2, 32'd0, rf_wr_data);
                pc_r = rf_wr_data;
            end
            if (psw_we) begin
                observe(3, 32'd0, rf_wr_data);
                psw_r = rf_wr_data;
            end
        end
    end

    function automatic int slot_reg(input int w, input bit up);
        if (w < 10) return up ? w + 6 : w - 2;
        return up ? 16 + w : 16 + w - 8;
    endfunction

    task automatic push_save(input bit up);
        logic [31:0] fr;
        fr = m_free;
        for (int w = 1; w < 16; w++) begin
            ev_t e;
            e.kind = 0;
            e.a    = fr + 32'(4 * w);
            e.d    = (w == 1) ? (up ? psw_r : pc_r) : rf[slot_reg(w, up)];
            exp_q.push_back(e);
        end
        exp_q.push_back('{0, fr, m_prev});
        m_free = mem[fr[9:2]] & 32'hFFFF_FFC0;
        m_prev = fr;
    endtask

    task automatic push_restore(input bit up);
        logic [31:0] fr;
        fr = m_prev;
        for (int w = 1; w < 16; w++) begin
            ev_t e;
            e.kind = (w == 1) ? (up ? 3 : 2) : 1;
            e.a    = (w == 1) ? 32'd0 : 32'(slot_reg(w, up));
            e.d    = mem[fr[9:2] + 8'(w)];
            exp_q.push_back(e);
        end
        exp_q.push_back('{0, fr, m_free});
        m_prev = mem[fr[9:2]] & 32'hFFFF_FFC0;
        m_free = fr;
    endtask

    // vec = {restore_lower, restore_upper, save_lower, save_upper}; win = served op
    task automatic run_op(input logic [3:0] vec, input int win, input bit exp_err, input bit intrude, input string tag);
        if (!exp_err) begin
            case (win)
                0: push_save(1'b1);
                1: push_save(1'b0);
                2: push_restore(1'b1);
                default: push_restore(1'b0);
            endcase
        end
        @(negedge clk);
        {rl, ru, sl, su} = vec;
        @(negedge clk);
        {rl, ru, sl, su} = 4'b0;
        if (exp_err) begin
            check(err === 1'b1, {tag, " error pulse"}, {31'd0, err}, 32'd1);
            check(!busy && !done && !mem_valid, {tag, " no activity"}, {29'd0, busy, done, mem_valid}, 32'd0);
            @(negedge clk);
            check(err === 1'b0, {tag, " error one cycle"}, {31'd0, err}, 32'd0);
            check(!mem_valid && !busy, {tag, " no beat"}, {30'd0, mem_valid, busy}, 32'd0);
        end else begin
            check(busy === 1'b1, "R7 busy after accept", {31'd0, busy}, 32'd1);
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (intrude && i == 2) sl = 1'b1;
                if (intrude && i == 3) sl = 1'b0;
                if (done) break;
                if (!busy) begin
                    check(1'b0, "R7 busy dropped early", 32'd0, 32'd1);
                    break;
                end
            end
            sl = 1'b0;
            check(done === 1'b1 && busy === 1'b0, "R7 done with busy low", {30'd0, done, busy}, 32'd2);
            @(negedge clk);
            check(done === 1'b0, "R7 done one cycle", {31'd0, done}, 32'd0);
            check(exp_q.size() == 0, {tag, " all beats seen"}, 32'(exp_q.size()), 32'd0);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(!busy && !mem_valid, "R9 no further operation", {30'd0, busy, mem_valid}, 32'd0);
            end
        end
        check(free_ptr == m_free, {tag, " free pointer"}, free_ptr, m_free);
        check(prev_ptr == m_prev, {tag, " previous pointer"}, prev_ptr, m_prev);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + 32'(i);
        mem[8'h10] = 32'h0000_0083;   // frame 0x40 -> 0x80, junk low bits
        mem[8'h20] = 32'h0000_00C0;   // frame 0x80 -> 0xC0
        mem[8'h30] = 32'h0000_0000;   // frame 0xC0 ends the list
        for (int i = 0; i < 32; i++) begin
            rf[i]      = 32'h1000_0000 + 32'(i * 32'h111);
            orig_rf[i] = rf[i];
        end
        pc_r = 32'hAAAA_0100; orig_pc = pc_r;
        psw_r = 32'h0000_0B80; orig_psw = psw_r;
        m_free = 32'h40;
        m_prev = 32'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(free_ptr == 32'h40, "R11 reset free", free_ptr, 32'h40);
        check(prev_ptr == 32'h0, "R11 reset previous", prev_ptr, 32'h0);
        check(!busy && !done && !err && !mem_valid, "R11 reset flags",
              {28'd0, busy, done, err, mem_valid}, 32'd0);

        run_op(4'b1000, 3, 1'b1, 1'b0, "R6");
        run_op(4'b0010, 1, 1'b0, 1'b0, "R1");
        check(free_ptr == 32'h80, "R10 link low bits cleared", free_ptr, 32'h80);
        check(mem[8'h11] == orig_pc, "R2 lower word1 pc", mem[8'h11], orig_pc);
        check(mem[8'h12] == orig_rf[0], "R2 lower word2 D0", mem[8'h12], orig_rf[0]);
        check(mem[8'h1A] == orig_rf[18], "R2 lower word10 A2", mem[8'h1A], orig_rf[18]);

        // R9: save upper and restore lower together, plus a save lower while busy
        run_op(4'b1001, 0, 1'b0, 1'b1, "R9");
        check(mem[8'h21] == orig_psw, "R2 upper word1 status", mem[8'h21], orig_psw);
        check(mem[8'h22] == orig_rf[8], "R2 upper word2 D8", mem[8'h22], orig_rf[8]);
        check(mem[8'h2A] == orig_rf[26], "R2 upper word10 A10", mem[8'h2A], orig_rf[26]);

        run_op(4'b0010, 1, 1'b0, 1'b0, "R1");
        run_op(4'b0001, 0, 1'b1, 1'b0, "R5");

        for (int i = 0; i < 32; i++) rf[i] = 32'hDEAD_0000 + 32'(i);
        pc_r = 32'hDEAD_1111;
        psw_r = 32'hDEAD_2222;

        run_op(4'b1000, 3, 1'b0, 1'b0, "R3");
        check(rf[3] == orig_rf[3], "R3 D3 reloaded", rf[3], orig_rf[3]);
        check(rf[21] == orig_rf[21], "R3 A5 reloaded", rf[21], orig_rf[21]);
        check(pc_r == orig_pc, "R3 pc reloaded", pc_r, orig_pc);
        run_op(4'b0100, 2, 1'b0, 1'b0, "R3");
        check(rf[12] == orig_rf[12], "R3 D12 reloaded", rf[12], orig_rf[12]);
        check(psw_r == orig_psw, "R3 status reloaded", psw_r, orig_psw);
        run_op(4'b1000, 3, 1'b0, 1'b0, "R3");
        run_op(4'b0100, 2, 1'b1, 1'b0, "R6");

        check(rf[16] == 32'hDEAD_0010, "R4 A0 untouched", rf[16], 32'hDEAD_0010);
        check(rf[17] == 32'hDEAD_0011, "R4 A1 untouched", rf[17], 32'hDEAD_0011);
        check(rf[24] == 32'hDEAD_0018, "R4 A8 untouched", rf[24], 32'hDEAD_0018);
        check(rf[25] == 32'hDEAD_0019, "R4 A9 untouched", rf[25], 32'hDEAD_0019);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule